// File: doc/BRIEF.md
# Inter-Processor Signal Register

This block holds a small vector of flag bits shared by a host processor and a DSP. Each processor has its own register port. Through that port it can set flags by writing ones to a set register, or drop flags by writing ones to a separate clear register. Neither processor needs a read-modify-write sequence, so the two sides can raise and retire flags at the same time without losing each other's updates.

Each flag raises a request toward the other processor. The low half of the vector drives level interrupt requests to the DSP, and the high half drives level interrupt requests to the host. Each half is gated by an enable mask that stands in for the receiving processor's interrupt-controller enable. A processor reads the flag vector back on its own read-data port. Both register offsets return the same flag values.

Top module: `ipsig_top`

## Requirements
- R1: A synchronous active-low reset clears every flag bit, which also holds both interrupt outputs at zero.
- R2: A write with select and write strobe high to offset 0 (set register) sets, at the next clock edge, every flag bit whose write-data bit is 1.
- R3: A write with select and write strobe high to offset 1 (clear register) clears, at the next clock edge, every flag bit whose write-data bit is 1.
- R4: Write-data bits that are 0 leave the matching flag bits unchanged, on both the set register and the clear register.
- R5: Either port may set or clear any flag bit. When both ports write in the same cycle, all of their updates take effect together.
- R6: If one bit is both set and cleared in the same cycle, whether by one port or by two, the bit ends up set.
- R7: Both read-data ports always return the current flag vector, whatever the address.
- R8: dsp_irq[i] equals flag bit i ANDed with dsp_irq_en[i]. host_irq[i] equals flag bit N/2+i ANDed with host_irq_en[i].
- R9: An interrupt output stays asserted for as long as its flag bit is set and enabled. Changing an enable mask never changes the flag bits.
- R10: A cycle in which select or the write strobe is low changes no flag bit, whatever the address and data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | Host port select |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 1 | Host register offset: 0 set, 1 clear |
| host_wdata | input | N | Host write data |
| host_rdata | output | N | Flag vector seen by host |
| dsp_sel | input | 1 | DSP port select |
| dsp_wr | input | 1 | DSP write strobe |
| dsp_addr | input | 1 | DSP register offset: 0 set, 1 clear |
| dsp_wdata | input | N | DSP write data |
| dsp_rdata | output | N | Flag vector seen by DSP |
| dsp_irq_en | input | N/2 | DSP interrupt enable mask |
| host_irq_en | input | N/2 | Host interrupt enable mask |
| dsp_irq | output | N/2 | Level interrupts to DSP (low flag half) |
| host_irq | output | N/2 | Level interrupts to host (high flag half) |

## Verification
The assertions assume that every port input is a known value at each rising clock edge once reset has been released. They also assume that the clear-register check only makes sense after a clean reset, since they compare each cycle's flags with the writes of the cycle before. The stimulus keeps within these limits. It drives every input on the falling edge and never leaves one undefined. It holds reset across several clock edges before releasing it, and it changes the enable masks only on falling edges, so an interrupt output is never sampled while it is still settling.

// File: rtl/ipsig_pkg.sv
// Package: shared register-offset encoding for the signal register ports.
// Assumes a single address bit per port selects one of two registers.
package ipsig_pkg;
    typedef enum logic {
        REG_SET = 1'b0,
        REG_CLR = 1'b1
    } ipsig_reg_e;
endpackage

// File: rtl/ipsig_port_decode.sv
// Module: ipsig_port_decode
// Turns one processor's register write into a set mask and a clear mask.
// Assumes: sel/wr are qualified strobes, and a write of zero bits is a no-op.
module ipsig_port_decode
    import ipsig_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         sel,
    input  logic         wr,
    input  logic         addr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] set_mask,
    output logic [N-1:0] clr_mask
);
    logic wr_en;

    // Purpose: qualify the write with both strobes.
    always_comb wr_en = sel & wr;

    // Purpose: route write data to the set or clear mask by offset.
    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        if (wr_en) begin
            if (ipsig_reg_e'(addr) == REG_SET) set_mask = wdata;
            else                               clr_mask = wdata;
        end
    end
endmodule

// File: rtl/ipsig_bit_store.sv
// Module: ipsig_bit_store
// Holds the flag vector and merges set/clear masks from every port.
// Assumes: set has priority over clear for the same bit in one cycle.
module ipsig_bit_store #(
    parameter int N         = 8,
    parameter int NUM_PORTS = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_PORTS-1:0][N-1:0]    set_masks,
    input  logic [NUM_PORTS-1:0][N-1:0]    clr_masks,
    output logic [N-1:0]                   flags
);
    logic [N-1:0] set_any;
    logic [N-1:0] clr_any;
    logic [N-1:0] flags_nxt;

    // Purpose: OR together the masks of all ports.
    always_comb begin
        set_any = '0;
        clr_any = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            set_any |= set_masks[p];
            clr_any |= clr_masks[p];
        end
    end

    // Purpose: apply clears first, then sets so a set wins.
    always_comb flags_nxt = (flags & ~clr_any) | set_any;

    // Purpose: flag register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= flags_nxt;
    end
endmodule

// File: rtl/ipsig_irq_gate.sv
// Module: ipsig_irq_gate
// Gates one half of the flag vector with a receiver's enable mask.
// Assumes: outputs are level requests consumed by a downstream controller.
module ipsig_irq_gate #(
    parameter int W = 4
) (
    input  logic [W-1:0] flags_half,
    input  logic [W-1:0] enable,
    output logic [W-1:0] irq
);
    // Purpose: per-bit enable gating.
    always_comb irq = flags_half & enable;
endmodule

// File: rtl/ipsig_top.sv
// Module: ipsig_top
// Shared signal register between a host and a DSP. Each side has a set
// and a clear register; the low flag half interrupts the DSP, the high
// half interrupts the host.
// Assumes: N is even; bus arbitration is handled outside this block.
module ipsig_top #(
    parameter int N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_sel,
    input  logic             host_wr,
    input  logic             host_addr,
    input  logic [N-1:0]     host_wdata,
    output logic [N-1:0]     host_rdata,
    input  logic             dsp_sel,
    input  logic             dsp_wr,
    input  logic             dsp_addr,
    input  logic [N-1:0]     dsp_wdata,
    output logic [N-1:0]     dsp_rdata,
    input  logic [N/2-1:0]   dsp_irq_en,
    input  logic [N/2-1:0]   host_irq_en,
    output logic [N/2-1:0]   dsp_irq,
    output logic [N/2-1:0]   host_irq
);
    localparam int HALF      = N / 2;
    localparam int NUM_PORTS = 2;
    localparam int P_HOST    = 0;
    localparam int P_DSP     = 1;

    logic [NUM_PORTS-1:0]        p_sel;
    logic [NUM_PORTS-1:0]        p_wr;
    logic [NUM_PORTS-1:0]        p_addr;
    logic [NUM_PORTS-1:0][N-1:0] p_wdata;
    logic [NUM_PORTS-1:0][N-1:0] p_set;
    logic [NUM_PORTS-1:0][N-1:0] p_clr;
    logic [N-1:0]                flags;

    // Purpose: gather both processor ports into indexed arrays.
    always_comb begin
        p_sel[P_HOST]   = host_sel;
        p_wr[P_HOST]    = host_wr;
        p_addr[P_HOST]  = host_addr;
        p_wdata[P_HOST] = host_wdata;
        p_sel[P_DSP]    = dsp_sel;
        p_wr[P_DSP]     = dsp_wr;
        p_addr[P_DSP]   = dsp_addr;
        p_wdata[P_DSP]  = dsp_wdata;
    end

    genvar gp;
    generate
        for (gp = 0; gp < NUM_PORTS; gp++) begin : g_port
            ipsig_port_decode #(.N(N)) u_dec (
                .sel      (p_sel[gp]),
                .wr       (p_wr[gp]),
                .addr     (p_addr[gp]),
                .wdata    (p_wdata[gp]),
                .set_mask (p_set[gp]),
                .clr_mask (p_clr[gp])
            );
        end
    endgenerate

    ipsig_bit_store #(.N(N), .NUM_PORTS(NUM_PORTS)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_masks (p_set),
        .clr_masks (p_clr),
        .flags     (flags)
    );

    // Purpose: both register offsets read back the live flag vector.
    always_comb begin
        host_rdata = flags;
        dsp_rdata  = flags;
    end

    ipsig_irq_gate #(.W(HALF)) u_dsp_gate (
        .flags_half (flags[HALF-1:0]),
        .enable     (dsp_irq_en),
        .irq        (dsp_irq)
    );

    ipsig_irq_gate #(.W(HALF)) u_host_gate (
        .flags_half (flags[N-1:HALF]),
        .enable     (host_irq_en),
        .irq        (host_irq)
    );
endmodule

// File: rtl/ipsig_checker.sv
// Module: ipsig_checker
// Port-level properties of the signal register, bound onto ipsig_top.
// Assumes: inputs are known at each edge after reset is released.
module ipsig_checker #(
    parameter int N = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_sel,
    input logic             host_wr,
    input logic             host_addr,
    input logic [N-1:0]     host_wdata,
    input logic [N-1:0]     host_rdata,
    input logic             dsp_sel,
    input logic             dsp_wr,
    input logic             dsp_addr,
    input logic [N-1:0]     dsp_wdata,
    input logic [N-1:0]     dsp_rdata,
    input logic [N/2-1:0]   dsp_irq_en,
    input logic [N/2-1:0]   host_irq_en,
    input logic [N/2-1:0]   dsp_irq,
    input logic [N/2-1:0]   host_irq
);
    localparam int HALF = N / 2;

    logic [N-1:0] w_set;
    logic [N-1:0] w_clr;

    // Purpose: requested masks observed at the ports.
    always_comb begin
        w_set = ((host_sel && host_wr && !host_addr) ? host_wdata : '0)
              | ((dsp_sel  && dsp_wr  && !dsp_addr)  ? dsp_wdata  : '0);
        w_clr = ((host_sel && host_wr &&  host_addr) ? host_wdata : '0)
              | ((dsp_sel  && dsp_wr  &&  dsp_addr)  ? dsp_wdata  : '0);
    end

    // R1: first cycle out of reset shows an empty vector
    p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (host_rdata == '0 && dsp_irq == '0 && host_irq == '0));

    // R2, R6: requested sets are present after the edge
    p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((host_rdata & $past(w_set)) == $past(w_set)));

    // R3: cleared bits not also set are gone after the edge
    p_clear_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((host_rdata & $past(w_clr) & ~$past(w_set)) == '0));

    // R4, R10: untouched bits keep their value
    p_untouched_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (((host_rdata ^ $past(host_rdata))
                           & ~($past(w_set) | $past(w_clr))) == '0));

    // R7: both sides see the same vector
    p_same_view_r7: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata == dsp_rdata);

    // R8: interrupt outputs follow flags and enables
    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_irq == (dsp_rdata[HALF-1:0] & dsp_irq_en)) &&
        (host_irq == (host_rdata[N-1:HALF] & host_irq_en)));
endmodule

bind ipsig_top ipsig_checker #(.N(N)) u_ipsig_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_sel    (host_sel),
    .host_wr     (host_wr),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .dsp_sel     (dsp_sel),
    .dsp_wr      (dsp_wr),
    .dsp_addr    (dsp_addr),
    .dsp_wdata   (dsp_wdata),
    .dsp_rdata   (dsp_rdata),
    .dsp_irq_en  (dsp_irq_en),
    .host_irq_en (host_irq_en),
    .dsp_irq     (dsp_irq),
    .host_irq    (host_irq)
);

// File: tb/ipsig_top_bench.sv
// Bench: scoreboard for ipsig_top. The driver applies one cycle of stimulus
// on the falling edge and queues the expected result; the monitor compares
// shortly after the next rising edge.
module ipsig_top_bench;
    localparam int N    = 8;
    localparam int HALF = N / 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            host_sel = 1'b0, host_wr = 1'b0, host_addr = 1'b0;
    logic [N-1:0]    host_wdata = '0;
    logic            dsp_sel = 1'b0, dsp_wr = 1'b0, dsp_addr = 1'b0;
    logic [N-1:0]    dsp_wdata = '0;
    logic [HALF-1:0] dsp_irq_en = '0, host_irq_en = '0;
    logic [N-1:0]    host_rdata, dsp_rdata;
    logic [HALF-1:0] dsp_irq, host_irq;

    typedef struct {
        logic [N-1:0]    flags;
        logic [HALF-1:0] dirq;
        logic [HALF-1:0] hirq;
        string           tag;
    } exp_t;

    exp_t         sb[$];
    logic [N-1:0] model = '0;
    int           vectors = 0;
    int           miscompares = 0;
    bit           done = 1'b0;

    always #10 clk = ~clk;

    ipsig_top #(.N(N)) u_ipsig_top (
        .clk(clk), .rst_n(rst_n),
        .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .dsp_sel(dsp_sel), .dsp_wr(dsp_wr), .dsp_addr(dsp_addr),
        .dsp_wdata(dsp_wdata), .dsp_rdata(dsp_rdata),
        .dsp_irq_en(dsp_irq_en), .host_irq_en(host_irq_en),
        .dsp_irq(dsp_irq), .host_irq(host_irq)
    );

    // Driver: one cycle of stimulus, expected result queued for the monitor.
    task automatic step(input logic rst, input logic hs, input logic hw,
                        input logic ha, input logic [N-1:0] hd,
                        input logic ds, input logic dw, input logic da,
                        input logic [N-1:0] dd, input logic [HALF-1:0] de,
                        input logic [HALF-1:0] he, input string tag);
        logic [N-1:0] s, c;
        exp_t e;
        @(negedge clk);
        rst_n = rst; host_sel = hs; host_wr = hw; host_addr = ha; host_wdata = hd;
        dsp_sel = ds; dsp_wr = dw; dsp_addr = da; dsp_wdata = dd;
        dsp_irq_en = de; host_irq_en = he;
        s = ((hs && hw && !ha) ? hd : '0) | ((ds && dw && !da) ? dd : '0);
        c = ((hs && hw &&  ha) ? hd : '0) | ((ds && dw &&  da) ? dd : '0);
        if (!rst) model = '0;
        else      model = (model & ~c) | s;
        e.flags = model;
        e.dirq  = model[HALF-1:0] & de;
        e.hirq  = model[N-1:HALF] & he;
        e.tag   = tag;
        sb.push_back(e);
    endtask

    // Monitor: pop and compare mid-cycle after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                vectors++;
                if (host_rdata !== e.flags || dsp_rdata !== e.flags ||
                    dsp_irq !== e.dirq || host_irq !== e.hirq) begin
                    miscompares++;
                    $display("FAIL %s: rd h=%h d=%h irq d=%h h=%h, expected rd=%h irq d=%h h=%h",
                             e.tag, host_rdata, dsp_rdata, dsp_irq, host_irq,
                             e.flags, e.dirq, e.hirq);
                end
            end
        end
    end

    // Stimulus sequence.
    initial begin
        // R1: reset held while a set write is attempted
        step(0, 1,1,0,8'hFF, 1,1,0,8'hFF, 4'hF, 4'hF, "R1");
        step(0, 0,0,0,8'h00, 0,0,0,8'h00, 4'hF, 4'hF, "R1");
        // R2, R8: host sets low bits
        step(1, 1,1,0,8'h05, 0,0,0,8'h00, 4'hF, 4'hF, "R2");
        // R5, R8: DSP sets high bits
        step(1, 0,0,0,8'h00, 1,1,0,8'hA0, 4'hF, 4'hF, "R5");
        // R4: zero write to set register
        step(1, 1,1,0,8'h00, 0,0,0,8'h00, 4'hF, 4'hF, "R4");
        // R3: host clears bit 0
        step(1, 1,1,1,8'h01, 0,0,0,8'h00, 4'hF, 4'hF, "R3");
        // R4: zero write to clear register
        step(1, 0,0,0,8'h00, 1,1,1,8'h00, 4'hF, 4'hF, "R4");
        // R10: select without strobe, strobe without select
        step(1, 1,0,1,8'hFF, 1,0,0,8'hFF, 4'hF, 4'hF, "R10");
        step(1, 0,1,1,8'hFF, 0,1,0,8'h5A, 4'hF, 4'hF, "R10");
        // R6: host clears bit 7 while DSP sets it
        step(1, 1,1,1,8'h80, 1,1,0,8'h80, 4'hF, 4'hF, "R6");
        // R6: host sets bit 1 while DSP clears bits 1,2
        step(1, 1,1,0,8'h02, 1,1,1,8'h06, 4'hF, 4'hF, "R6");
        // R5: both ports set different bits together
        step(1, 1,1,0,8'h01, 1,1,0,8'h10, 4'hF, 4'hF, "R5");
        // R8: partial enables
        step(1, 0,0,0,8'h00, 0,0,0,8'h00, 4'h5, 4'hA, "R8");
        // R9: masks off, flags unchanged
        step(1, 0,0,0,8'h00, 0,0,0,8'h00, 4'h0, 4'h0, "R9");
        // R9: masks back on, requests return and persist
        for (int i = 0; i < 4; i++)
            step(1, 0,0,0,8'h00, 0,0,0,8'h00, 4'hF, 4'hF, "R9");
        // R3, R7: DSP clears everything
        step(1, 0,0,0,8'h00, 1,1,1,8'hFF, 4'hF, 4'hF, "R3");
        // R1: reset after activity
        step(1, 1,1,0,8'hC3, 0,0,0,8'h00, 4'hF, 4'hF, "R2");
        step(0, 0,0,0,8'h00, 0,0,0,8'h00, 4'hF, 4'hF, "R1");
        step(1, 0,0,0,8'h00, 0,0,0,8'h00, 4'hF, 4'hF, "R1");
        wait (sb.size() == 0);
        #30;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a miscompare.
    initial begin
        #(20 * 5000);
        if (!done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule